// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block computes a Hamming-style check code over one 512-byte flash page while the bytes move through the controller's data path. The same block serves program and read transfers. Software writes a command byte to a mode register to select what the block does. One command clears the accumulated code. Another command enables accumulation for the bytes that follow. A third command switches the data register into an ECC readout mode, where six consecutive reads return the check code one byte at a time.

The page is handled as two 256-byte halves. Each half has 16 line-parity bits and 6 column-parity bits. The readout interleaves the four line-parity bytes with the two column-parity bytes, and each column-parity byte carries ones in its two low bits.

A small state machine holds the mode. It has three states: `ST_IDLE`, `ST_DATA` and `ST_READOUT`. Every mode-register write moves it, from any state:
- `GO_DATA` (value 0xB0) leads to `ST_DATA`.
- `GO_READOUT` (value 0xD0) leads to `ST_READOUT` and rewinds the readout pointer.
- `GO_CLEAR` (value 0x70) leads to `ST_IDLE` and wipes all ECC state.
- `GO_OTHER` (any other value) leads to `ST_IDLE`.

When no mode-register write occurs, the state holds.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, and one cycle after a mode write of 0x70, the byte count and all parity bits are zero. A readout then yields 0x00, 0x00, 0x03, 0x00, 0x00, 0x03.
- R2: A mode write of 0xB0 selects data mode, 0xD0 selects ECC readout mode, and 0x70 or any other value selects idle. The new mode takes effect on the cycle after the write.
- R3: Within a half, for each byte-index bit k (0..7), line bit 2k is the XOR of the bytes' parities (XOR of all 8 bits) over bytes whose index bit k is 0. Line bit 2k+1 covers bytes whose index bit k is 1.
- R4: Within a half, for each bit-position bit m (0..2), column bit 2m is the XOR of all data bits whose position has bit m equal to 0. Column bit 2m+1 covers positions with bit m equal to 1.
- R5: Bytes 0..255 of the page feed line bits 15:0 and column bits 5:0. Bytes 256..511 feed line bits 31:16 and column bits 11:6.
- R6: In readout mode, the six bytes come in this order: line[7:0], line[15:8], {col[5:0],2'b11}, line[23:16], line[31:24], {col[11:6],2'b11}.
- R7: Entering readout mode points at the first byte. Each read strobe advances the pointer by one, and the pointer wraps to the first byte after the sixth.
- R8: Bytes offered after the 512th byte of a page leave the parity unchanged.
- R9: Data bytes offered outside data mode leave the parity unchanged.
- R10: Outside readout mode, `ecc_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_data | input | 8 | Command value written to the mode register |
| data_valid | input | 1 | One page byte transferred this cycle |
| data_byte | input | 8 | Byte on the flash data path |
| rd_strobe | input | 1 | Data-register read in readout mode |
| ecc_byte | output | 8 | ECC byte currently selected for readout |

## Verification
Each data byte enters the parity registers at the clock edge where it is offered. A mode write changes the state, and a read strobe moves the pointer, at the same kind of edge. `ecc_byte` is a combinational view of those registers, so every result is due one edge after its stimulus. The bench drives and samples on the falling edge. It reads `ecc_byte` before raising `rd_strobe`, and it lets the next falling edge pass before sampling the following byte. Expected bytes come from a software model of R3 to R6 applied to the same page.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DATA    = 2'd1,
        ST_READOUT = 2'd2
    } ecc_state_e;

    localparam logic [7:0] CMD_CLEAR   = 8'h70;
    localparam logic [7:0] CMD_DATA    = 8'hB0;
    localparam logic [7:0] CMD_READOUT = 8'hD0;

    localparam int ECC_BYTES = 6;
    localparam int PTR_W     = $clog2(ECC_BYTES);

endpackage

// File: rtl/ecc_mode_fsm.sv
module ecc_mode_fsm
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [7:0] mode_data,
    output ecc_state_e state_o,
    output logic       acc_mode_o,
    output logic       rd_mode_o,
    output logic       clear_o,
    output logic       enter_rd_o
);

    ecc_state_e state_q;
    ecc_state_e state_d;

    // Next state: every mode write moves the machine, whatever the present state
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            unique case (mode_data)
                CMD_DATA:    state_d = ST_DATA;     // GO_DATA
                CMD_READOUT: state_d = ST_READOUT;  // GO_READOUT
                default:     state_d = ST_IDLE;     // GO_CLEAR / GO_OTHER
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        acc_mode_o = 1'b0;
        rd_mode_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_DATA:    acc_mode_o = 1'b1;
            ST_READOUT: rd_mode_o  = 1'b1;
            default:    ;
        endcase
        clear_o    = mode_wr && (mode_data == CMD_CLEAR);
        enter_rd_o = mode_wr && (mode_data == CMD_READOUT);
    end

    assign state_o = state_q;

endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int BIT_IDX_W = $clog2(DATA_W),
    localparam int LP_W      = 2 * IDX_W,
    localparam int CP_W      = 2 * BIT_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output logic [LP_W-1:0]   lp,
    output logic [CP_W-1:0]   cp
);

    logic            byte_par;
    logic [LP_W-1:0] lp_upd;
    logic [CP_W-1:0] cp_upd;

    assign byte_par = ^data;

    // Line parity: one even/odd pair per index bit
    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        assign lp_upd[2*k]   = byte_par & ~idx[k];
        assign lp_upd[2*k+1] = byte_par &  idx[k];
    end

    // Column parity: one even/odd pair per bit-position bit
    for (genvar m = 0; m < BIT_IDX_W; m++) begin : g_col
        always_comb begin
            cp_upd[2*m]   = 1'b0;
            cp_upd[2*m+1] = 1'b0;
            for (int b = 0; b < DATA_W; b++) begin
                if (((b >> m) & 1) != 0) cp_upd[2*m+1] = cp_upd[2*m+1] ^ data[b];
                else                     cp_upd[2*m]   = cp_upd[2*m]   ^ data[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp <= '0;
            cp <= '0;
        end else if (clear) begin
            lp <= '0;
            cp <= '0;
        end else if (en) begin
            lp <= lp ^ lp_upd;
            cp <= cp ^ cp_upd;
        end
    end

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LP_W   = 32,
    parameter int CP_W   = 12,
    localparam int Q_W   = LP_W / 4,
    localparam int H_W   = CP_W / 2,
    localparam int PAD_W = DATA_W - H_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_rd,
    input  logic              rd_mode,
    input  logic              rd_strobe,
    input  logic [LP_W-1:0]   lp,
    input  logic [CP_W-1:0]   cp,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] ecc_byte
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ECC_BYTES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     ptr <= '0;
        else if (enter_rd)              ptr <= '0;
        else if (rd_mode && rd_strobe)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    logic [DATA_W-1:0] sel;

    always_comb begin
        unique case (ptr)
            3'd0:    sel = lp[0*Q_W +: Q_W];
            3'd1:    sel = lp[1*Q_W +: Q_W];
            3'd2:    sel = {cp[0 +: H_W], {PAD_W{1'b1}}};
            3'd3:    sel = lp[2*Q_W +: Q_W];
            3'd4:    sel = lp[3*Q_W +: Q_W];
            3'd5:    sel = {cp[H_W +: H_W], {PAD_W{1'b1}}};
            default: sel = '0;
        endcase
        ecc_byte = rd_mode ? sel : '0;
    end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [7:0]        mode_data,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] ecc_byte
);

    localparam int HALVES     = 2;
    localparam int HALF_BYTES = PAGE_BYTES / HALVES;
    localparam int IDX_W      = $clog2(HALF_BYTES);
    localparam int CNT_W      = $clog2(PAGE_BYTES) + 1;
    localparam int LPH_W      = 2 * IDX_W;
    localparam int CPH_W      = 2 * $clog2(DATA_W);

    ecc_state_e              state_q;
    logic                    acc_mode, rd_mode, clear, enter_rd;
    logic [CNT_W-1:0]        byte_cnt;
    logic                    accept;
    logic [HALVES*LPH_W-1:0] lp_all;
    logic [HALVES*CPH_W-1:0] cp_all;
    logic [PTR_W-1:0]        rd_ptr;

    ecc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_data  (mode_data),
        .state_o    (state_q),
        .acc_mode_o (acc_mode),
        .rd_mode_o  (rd_mode),
        .clear_o    (clear),
        .enter_rd_o (enter_rd)
    );

    assign accept = acc_mode && data_valid && (byte_cnt < CNT_W'(PAGE_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      byte_cnt <= '0;
        else if (clear)  byte_cnt <= '0;
        else if (accept) byte_cnt <= byte_cnt + 1'b1;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ecc_half_acc #(
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .en    (accept && (byte_cnt[IDX_W] == 1'(h))),
            .idx   (byte_cnt[IDX_W-1:0]),
            .data  (data_byte),
            .lp    (lp_all[h*LPH_W +: LPH_W]),
            .cp    (cp_all[h*CPH_W +: CPH_W])
        );
    end

    ecc_readout #(
        .DATA_W (DATA_W),
        .LP_W   (HALVES*LPH_W),
        .CP_W   (HALVES*CPH_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_rd  (enter_rd),
        .rd_mode   (rd_mode),
        .rd_strobe (rd_strobe),
        .lp        (lp_all),
        .cp        (cp_all),
        .ptr       (rd_ptr),
        .ecc_byte  (ecc_byte)
    );

endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk
    import nand_ecc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int PAGE_BYTES = 512,
    parameter int LP_W       = 32,
    parameter int CP_W       = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [7:0]       mode_data,
    input logic             data_valid,
    input logic [7:0]       ecc_byte,
    input ecc_state_e       state_q,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [LP_W-1:0]  lp_all,
    input logic [CP_W-1:0]  cp_all,
    input logic [PTR_W-1:0] rd_ptr
);

    logic clr_now;
    assign clr_now = mode_wr && (mode_data == CMD_CLEAR);

    a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (byte_cnt == '0) && (lp_all == '0) && (cp_all == '0));

    a_r2_readout_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && (mode_data == CMD_READOUT) |=> state_q == ST_READOUT);

    a_r7_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && (mode_data == CMD_READOUT) |=> rd_ptr == '0);

    a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr < PTR_W'(ECC_BYTES));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(PAGE_BYTES));

    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == CNT_W'(PAGE_BYTES)) && !clr_now |=> $stable(lp_all) && $stable(cp_all));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !((state_q == ST_DATA) && data_valid) && !clr_now |=> $stable(lp_all) && $stable(cp_all));

    a_r10_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READOUT) |-> ecc_byte == 8'h00);

endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES),
    .LP_W       (HALVES*LPH_W),
    .CP_W       (HALVES*CPH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_data  (mode_data),
    .data_valid (data_valid),
    .ecc_byte   (ecc_byte),
    .state_q    (state_q),
    .byte_cnt   (byte_cnt),
    .lp_all     (lp_all),
    .cp_all     (cp_all),
    .rd_ptr     (rd_ptr)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_data = 8'h00;
    logic       data_valid = 1'b0;
    logic [7:0] data_byte = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] ecc_byte;

    int tests = 0;
    int fails = 0;

    logic [7:0]  pg [512];
    logic [7:0]  exp_b [6];

    always #5 clk = ~clk;

    nand_ecc_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_data  (mode_data),
        .data_valid (data_valid),
        .data_byte  (data_byte),
        .rd_strobe  (rd_strobe),
        .ecc_byte   (ecc_byte)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [7:0] v);
        @(negedge clk);
        mode_wr = 1'b1; mode_data = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        data_valid = 1'b1; data_byte = v;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    // Sample the selected byte, then strobe one read
    task automatic read_one(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, ecc_byte, exp);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // Model of R3, R4, R5 and R6 over pg
    task automatic model();
        logic [31:0] lp;
        logic [11:0] cp;
        lp = '0; cp = '0;
        for (int i = 0; i < 512; i++) begin
            int h;
            int j;
            h = i / 256; j = i % 256;
            if (^pg[i]) begin
                for (int k = 0; k < 8; k++)
                    lp[h*16 + 2*k + ((j >> k) & 1)] ^= 1'b1;
            end
            for (int b = 0; b < 8; b++)
                if (pg[i][b])
                    for (int m = 0; m < 3; m++)
                        cp[h*6 + 2*m + ((b >> m) & 1)] ^= 1'b1;
        end
        exp_b[0] = lp[7:0];
        exp_b[1] = lp[15:8];
        exp_b[2] = {cp[5:0], 2'b11};
        exp_b[3] = lp[23:16];
        exp_b[4] = lp[31:24];
        exp_b[5] = {cp[11:6], 2'b11};
    endtask

    task automatic zero_page();
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    endtask

    task automatic run_page(input string req);
        set_mode(8'h70);
        set_mode(8'hB0);
        for (int i = 0; i < 512; i++) push(pg[i]);
        model();
        set_mode(8'hD0);
        for (int n = 0; n < 6; n++) read_one(req, exp_b[n]);
    endtask

    task automatic t_reset();
        check("R10 reset idle output", ecc_byte, 8'h00);
        zero_page(); model();
        set_mode(8'hD0);
        for (int n = 0; n < 6; n++) read_one("R1 reset readout", exp_b[n]);
    endtask

    task automatic t_single_low();
        zero_page(); pg[5] = 8'h01;
        run_page("R3 R4 R6 single byte idx5");
        check("R3 line byte0 value", exp_b[0], 8'h66);
        check("R4 column byte value", exp_b[2], 8'h57);
    endtask

    task automatic t_single_high();
        zero_page(); pg[300] = 8'h80;
        run_page("R5 upper half byte");
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 512; i++) pg[i] = 8'((i * 7 + 3) ^ (i >> 3));
        run_page("R3 R4 R5 R6 mixed page");
    endtask

    task automatic t_overflow();
        set_mode(8'hB0);
        for (int n = 0; n < 4; n++) push(8'hA5);
        set_mode(8'hD0);
        for (int n = 0; n < 6; n++) read_one("R8 extra bytes ignored", exp_b[n]);
    endtask

    task automatic t_wrap();
        set_mode(8'hD0);
        for (int n = 0; n < 6; n++) read_one("R7 sequence", exp_b[n]);
        read_one("R7 wrap to first", exp_b[0]);
        read_one("R7 after wrap", exp_b[1]);
        set_mode(8'hD0);
        read_one("R7 rewind on entry", exp_b[0]);
    endtask

    task automatic t_quiet();
        set_mode(8'h00);
        @(negedge clk);
        check("R10 idle output zero", ecc_byte, 8'h00);
        set_mode(8'hB0);
        @(negedge clk);
        check("R10 data mode output zero", ecc_byte, 8'h00);
    endtask

    task automatic t_ignore();
        set_mode(8'h70);
        set_mode(8'h33);
        for (int n = 0; n < 5; n++) push(8'h01 << n);
        set_mode(8'hD0);
        for (int n = 0; n < 5; n++) push(8'hFF);
        set_mode(8'hD0);
        zero_page(); model();
        for (int n = 0; n < 6; n++) read_one("R9 R2 bytes outside data mode", exp_b[n]);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 512; i++) pg[i] = 8'(i ^ 8'h5C);
        run_page("R3 R6 second pattern");
        set_mode(8'h70);
        set_mode(8'hD0);
        zero_page(); model();
        for (int n = 0; n < 6; n++) read_one("R1 clear command", exp_b[n]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_low();
        t_single_high();
        t_mixed();
        t_overflow();
        t_wrap();
        t_quiet();
        t_ignore();
        t_clear();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule